// File: doc/BRIEF.md
# Endpoint BAR Sizing Register Unit

This block holds the configuration-space state that decides the size and location of one memory Base Address Register in a PCIe endpoint. A parameter selects one of three sizing schemes. With a fixed mask the size is a constant. With a programmable mask, local software writes the size minus one into a shadow mask register. With a resizable BAR, software writes a capability word that lists the supported sizes. The hardware then picks the selected size and derives the BAR mask from it, so software never writes a mask in that scheme.

Local software uses two register ports. The standard port reaches the BAR words (low and high), the resizable capability word and the resizable control word. The shadow port reaches the two BAR mask words and a gate bit that unlocks writes to fields the host sees as read-only. The host reaches the BAR through its own config port. It sizes the BAR in the usual way: it writes all ones and reads back a value in which every address bit below the size reads as zero. The block handles 32-bit BARs and 64-bit BAR pairs. It also drives the enable, the effective base and the effective mask for the address decoder.

Top module: `bar_sizing_unit`

## Requirements
- R1: After reset the BAR is disabled. Host reads return zero and the flag nibble is 0. The capability word reads 0x0000_0010 (1 MB only), the selected size is 0, and the write-enable gate (shadow word 2, bit 0) is 0.
- R2: While the gate is 0, local writes are ignored. This covers the flag nibble (BAR low word bits 3:0), the capability word, the extended-size field of the control word, and both shadow mask words including the enable bit.
- R3: While the enable (bit 0 of shadow word 0) is 0, bar_en is low, host reads return zero and host writes to the BAR are ignored.
- R4: In programmable mode (scheme 1), the shadow low word sets mask bits 31:1 and bit 0 of that word is the enable. A host write of all ones then reads back the inverted mask in bits 31:4, with the flags in bits 3:0.
- R5: For a 64-bit BAR (flag bits 2:1 = 2'b10), shadow word 1 sets mask bits 63:32 and the BAR high word reads back the inverted upper mask after an all-ones host write.
- R6: In fixed mode (scheme 0), the mask equals the FIXED_MASK parameter (bits 3:0 forced to one). Shadow mask writes change only the enable bit.
- R7: In resizable mode (scheme 2), a gated capability write sets the selected size n to (index of the lowest set bit at or above bit 4) minus 4. Bits 3:0 of the written value are ignored. A write with no bit set at or above bit 4 leaves n unchanged.
- R8: In resizable mode, the mask is 2^(n+20)-1, derived from n alone. Writes to the shadow mask words change only the enable bit.
- R9: The control word holds the BAR index in bits 2:0, the count of resizable BARs in bits 7:5, n in bits 13:8 and the extended sizes in bits 31:16. Only bits 31:16 are writable, and they can be cleared. In schemes 0 and 1 the capability and control words read zero.
- R10: A host write stores only the address bits above the mask, so bits under the mask always read zero. The BAR base output carries the stored bits with zeros below the mask.
- R11: Flag bits 3:0 are read-only to the host. Bit 0 is the space indicator, bits 2:1 the type and bit 3 prefetchable. For a 32-bit BAR the high word reads zero, ignores host writes, and the upper half of the mask output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcl_wr | input | 1 | Standard local port write strobe |
| lcl_addr | input | 2 | Standard word select: 0 BAR low, 1 BAR high, 2 capability, 3 control |
| lcl_wdata | input | 32 | Standard local write data |
| lcl_rdata | output | 32 | Standard local read data for lcl_addr |
| shd_wr | input | 1 | Shadow port write strobe |
| shd_addr | input | 2 | Shadow word select: 0 mask low and enable, 1 mask high, 2 gate |
| shd_wdata | input | 32 | Shadow write data |
| shd_rdata | output | 32 | Shadow read data for shd_addr |
| hst_wr | input | 1 | Host config write strobe to the BAR |
| hst_hi | input | 1 | Host selects the BAR high word |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for the selected BAR word |
| bar_en | output | 1 | BAR is enabled for decode |
| bar_base | output | 64 | Effective base address |
| bar_mask | output | 64 | Effective address mask (ones are offset bits) |

## Verification
On every cycle the assertions check four things. A closed gate freezes the enable, the capability word and the flags. A disabled BAR keeps its base under host writes. Host reads never show address bits under the mask. The selected size moves only on a gated capability write, and the resizable mask stays a contiguous run of low ones. The exact readback values need the bench's scenarios. This covers the all-ones sizing response for every programmable size from 16 bytes to 16 TB, every resizable size from 1 MB to 128 TB, fixed-mode immunity to mask writes, the lowest-bit choice among several capability bits, the control-word layout, and the switch between 32-bit and 64-bit types.

// File: rtl/bar_sizing_pkg.sv
package bar_sizing_pkg;

  typedef enum logic [1:0] {
    SZ_FIXED  = 2'd0,
    SZ_PROG   = 2'd1,
    SZ_RESIZE = 2'd2,
    SZ_BAD    = 2'd3
  } sizing_e;

  localparam int DW        = 32;
  localparam int AW        = 64;
  localparam int SEL_W     = 6;
  localparam int CAP_LSB   = 4;
  localparam int MIN_SHIFT = 20;
  localparam int FLAG_W    = 4;

  localparam logic [1:0] LCL_BAR_LO = 2'd0;
  localparam logic [1:0] LCL_BAR_HI = 2'd1;
  localparam logic [1:0] LCL_CAP    = 2'd2;
  localparam logic [1:0] LCL_CTRL   = 2'd3;

  localparam logic [1:0] SHD_MASK_LO = 2'd0;
  localparam logic [1:0] SHD_MASK_HI = 2'd1;
  localparam logic [1:0] SHD_GATE    = 2'd2;

  localparam logic [1:0] TYPE_64 = 2'b10;

  // {found, index-4} of the lowest set bit at or above CAP_LSB
  function automatic logic [SEL_W:0] pick_size(input logic [DW-1:0] cap);
    logic [SEL_W:0] r;
    r = '0;
    for (int b = DW - 1; b >= CAP_LSB; b--) begin
      if (cap[b]) r = {1'b1, SEL_W'(b - CAP_LSB)};
    end
    return r;
  endfunction

  function automatic logic [AW-1:0] size_mask(input logic [SEL_W-1:0] sel);
    logic [SEL_W:0] sh;
    sh = {1'b0, sel} + (SEL_W + 1)'(MIN_SHIFT);
    if (sh >= (SEL_W + 1)'(AW)) return '1;
    return (AW'(1) << sh) - AW'(1);
  endfunction

endpackage

// File: rtl/bar_mask_unit.sv
module bar_mask_unit
  import bar_sizing_pkg::*;
#(
  parameter int               SCHEME     = 2,
  parameter logic [AW-1:0]    FIXED_MASK = 64'h0000_0000_0000_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ro_gate,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] derived,
  output logic          en_o,
  output logic [AW-1:0] mask_o
);

  localparam logic [AW-1:0] MIN_MASK = AW'((1 << FLAG_W) - 1);

  logic we_lo, we_hi;
  logic en_q, en_d;

  assign we_lo = wr_lo & ro_gate;
  assign we_hi = wr_hi & ro_gate;

  always_comb begin
    en_d = en_q;
    if (we_lo) en_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  generate
    if (SCHEME == int'(SZ_PROG)) begin : g_prog
      logic [AW-1:0] mask_q, mask_d;
      always_comb begin
        mask_d = mask_q;
        if (we_lo) mask_d[DW-1:0]  = {wdata[DW-1:1], 1'b1};
        if (we_hi) mask_d[AW-1:DW] = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
      end
      assign mask_o = mask_q | MIN_MASK;
      logic unused_prog;
      assign unused_prog = ^derived;
    end else if (SCHEME == int'(SZ_FIXED)) begin : g_fixed
      assign mask_o = FIXED_MASK | MIN_MASK;
      logic unused_fixed;
      assign unused_fixed = ^{we_hi, wdata[DW-1:1], derived};
    end else if (SCHEME == int'(SZ_RESIZE)) begin : g_resize
      assign mask_o = derived | MIN_MASK;
      logic unused_resize;
      assign unused_resize = ^{we_hi, wdata[DW-1:1]};
    end else begin : g_bad
      $error("bar_mask_unit: sizing scheme 3 is not a valid encoding");
      assign mask_o = '1;
      logic unused_bad;
      assign unused_bad = ^{we_hi, wdata[DW-1:1], derived};
    end
  endgenerate

  // R2
  shadow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ro_gate && wr_lo) |=> $stable(en_o))
    else $error("shadow write passed a closed gate");

endmodule

// File: rtl/rebar_regs.sv
module rebar_regs
  import bar_sizing_pkg::*;
#(
  parameter logic [2:0]  BAR_IDX   = 3'd2,
  parameter logic [2:0]  REBAR_NUM = 3'd1,
  parameter logic [15:0] EXT_RST   = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ro_gate,
  input  logic          cap_wr,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cap_o,
  output logic [DW-1:0] ctrl_o,
  output logic [AW-1:0] mask_o
);

  localparam logic [DW-1:0] CAP_RST = DW'(1) << CAP_LSB;

  logic [DW-1:0]    cap_q, cap_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [15:0]      ext_q, ext_d;
  logic [SEL_W:0]   pick;
  logic             cap_we, ctrl_we;

  assign cap_we  = cap_wr & ro_gate;
  assign ctrl_we = ctrl_wr & ro_gate;
  assign pick    = pick_size(wdata);

  always_comb begin
    cap_d = cap_q;
    sel_d = sel_q;
    ext_d = ext_q;
    if (cap_we) begin
      cap_d = wdata;
      if (pick[SEL_W]) sel_d = pick[SEL_W-1:0];
    end
    if (ctrl_we) ext_d = wdata[DW-1:16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= CAP_RST;
      sel_q <= '0;
      ext_q <= EXT_RST;
    end else begin
      cap_q <= cap_d;
      sel_q <= sel_d;
      ext_q <= ext_d;
    end
  end

  assign cap_o  = cap_q;
  assign ctrl_o = {ext_q, 2'b00, sel_q, REBAR_NUM, 2'b00, BAR_IDX};
  assign mask_o = size_mask(sel_q);

  // R2
  cap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ro_gate && (cap_wr || ctrl_wr)) |=> ($stable(cap_o) && $stable(ctrl_o)))
    else $error("capability or control write passed a closed gate");

  // R7
  sel_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o[13:8]) |-> $past(cap_we))
    else $error("selected size moved without a capability write");

endmodule

// File: rtl/bar_addr_reg.sv
module bar_addr_reg
  import bar_sizing_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ro_gate,
  input  logic          lcl_wr_lo,
  input  logic          lcl_wr_hi,
  input  logic [DW-1:0] lcl_wdata,
  input  logic          hst_wr,
  input  logic          hst_hi,
  input  logic [DW-1:0] hst_wdata,
  input  logic          en,
  input  logic [AW-1:0] mask,
  output logic [DW-1:0] hst_rdata,
  output logic [DW-1:0] raw_lo,
  output logic [DW-1:0] raw_hi,
  output logic [AW-1:0] base_o,
  output logic          is64_o
);

  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [AW-1:FLAG_W] base_q, base_d;
  logic              is64;
  logic [AW-1:0]     eff_base;
  logic              hwe;

  assign is64 = (flags_q[2:1] == TYPE_64);
  assign hwe  = hst_wr & en;

  always_comb begin
    flags_d = flags_q;
    base_d  = base_q;
    if (lcl_wr_lo) begin
      if (ro_gate) flags_d = lcl_wdata[FLAG_W-1:0];
      base_d[DW-1:FLAG_W] = lcl_wdata[DW-1:FLAG_W] & ~mask[DW-1:FLAG_W];
    end
    if (lcl_wr_hi && is64) base_d[AW-1:DW] = lcl_wdata & ~mask[AW-1:DW];
    if (hwe && !hst_hi)
      base_d[DW-1:FLAG_W] = hst_wdata[DW-1:FLAG_W] & ~mask[DW-1:FLAG_W];
    if (hwe && hst_hi && is64)
      base_d[AW-1:DW] = hst_wdata & ~mask[AW-1:DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      base_q  <= '0;
    end else begin
      flags_q <= flags_d;
      base_q  <= base_d;
    end
  end

  always_comb begin
    eff_base = '0;
    eff_base[DW-1:FLAG_W] = base_q[DW-1:FLAG_W] & ~mask[DW-1:FLAG_W];
    if (is64) eff_base[AW-1:DW] = base_q[AW-1:DW] & ~mask[AW-1:DW];
  end

  assign raw_lo = {eff_base[DW-1:FLAG_W], flags_q};
  assign raw_hi = eff_base[AW-1:DW];
  assign base_o = eff_base;
  assign is64_o = is64;

  always_comb begin
    hst_rdata = '0;
    if (en) hst_rdata = hst_hi ? raw_hi : raw_lo;
  end

  logic unused_hw;
  assign unused_hw = ^hst_wdata[FLAG_W-1:0];

  // R3
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && hst_wr && !lcl_wr_lo && !lcl_wr_hi) |=> $stable(base_o))
    else $error("disabled BAR accepted a host write");

  // R10
  addr_below_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hst_hi) |-> ((hst_rdata[DW-1:FLAG_W] & mask[DW-1:FLAG_W]) == '0))
    else $error("address bits under the mask are visible");

  // R11
  flags_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && !lcl_wr_lo) |=> $stable(raw_lo[FLAG_W-1:0]))
    else $error("host write changed the flag bits");

endmodule

// File: rtl/bar_sizing_unit.sv
module bar_sizing_unit
  import bar_sizing_pkg::*;
#(
  parameter int            SCHEME     = 2,
  parameter logic [63:0]   FIXED_MASK = 64'h0000_0000_0000_FFFF,
  parameter logic [2:0]    BAR_IDX    = 3'd2,
  parameter logic [2:0]    REBAR_NUM  = 3'd1,
  parameter logic [15:0]   EXT_RST    = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lcl_wr,
  input  logic [1:0]  lcl_addr,
  input  logic [31:0] lcl_wdata,
  output logic [31:0] lcl_rdata,
  input  logic        shd_wr,
  input  logic [1:0]  shd_addr,
  input  logic [31:0] shd_wdata,
  output logic [31:0] shd_rdata,
  input  logic        hst_wr,
  input  logic        hst_hi,
  input  logic [31:0] hst_wdata,
  output logic [31:0] hst_rdata,
  output logic        bar_en,
  output logic [63:0] bar_base,
  output logic [63:0] bar_mask
);

  logic          gate_q, gate_d;
  logic          en;
  logic [AW-1:0] mask, derived;
  logic [DW-1:0] cap_w, ctrl_w, raw_lo, raw_hi;
  logic          is64;

  always_comb begin
    gate_d = gate_q;
    if (shd_wr && shd_addr == SHD_GATE) gate_d = shd_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  generate
    if (SCHEME == int'(SZ_RESIZE)) begin : g_rebar
      rebar_regs #(
        .BAR_IDX  (BAR_IDX),
        .REBAR_NUM(REBAR_NUM),
        .EXT_RST  (EXT_RST)
      ) i_rebar (
        .clk    (clk),
        .rst_n  (rst_n),
        .ro_gate(gate_q),
        .cap_wr (lcl_wr && lcl_addr == LCL_CAP),
        .ctrl_wr(lcl_wr && lcl_addr == LCL_CTRL),
        .wdata  (lcl_wdata),
        .cap_o  (cap_w),
        .ctrl_o (ctrl_w),
        .mask_o (derived)
      );
    end else begin : g_norebar
      assign cap_w   = '0;
      assign ctrl_w  = '0;
      assign derived = size_mask('0);
    end
  endgenerate

  bar_mask_unit #(
    .SCHEME    (SCHEME),
    .FIXED_MASK(FIXED_MASK)
  ) i_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .ro_gate(gate_q),
    .wr_lo  (shd_wr && shd_addr == SHD_MASK_LO),
    .wr_hi  (shd_wr && shd_addr == SHD_MASK_HI),
    .wdata  (shd_wdata),
    .derived(derived),
    .en_o   (en),
    .mask_o (mask)
  );

  bar_addr_reg i_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ro_gate  (gate_q),
    .lcl_wr_lo(lcl_wr && lcl_addr == LCL_BAR_LO),
    .lcl_wr_hi(lcl_wr && lcl_addr == LCL_BAR_HI),
    .lcl_wdata(lcl_wdata),
    .hst_wr   (hst_wr),
    .hst_hi   (hst_hi),
    .hst_wdata(hst_wdata),
    .en       (en),
    .mask     (mask),
    .hst_rdata(hst_rdata),
    .raw_lo   (raw_lo),
    .raw_hi   (raw_hi),
    .base_o   (bar_base),
    .is64_o   (is64)
  );

  always_comb begin
    unique case (lcl_addr)
      LCL_BAR_LO: lcl_rdata = raw_lo;
      LCL_BAR_HI: lcl_rdata = raw_hi;
      LCL_CAP:    lcl_rdata = cap_w;
      default:    lcl_rdata = ctrl_w;
    endcase
  end

  always_comb begin
    case (shd_addr)
      SHD_MASK_LO: shd_rdata = {mask[DW-1:1], en};
      SHD_MASK_HI: shd_rdata = mask[AW-1:DW];
      SHD_GATE:    shd_rdata = {31'd0, gate_q};
      default:     shd_rdata = '0;
    endcase
  end

  assign bar_en   = en;
  assign bar_mask = is64 ? mask : {32'd0, mask[DW-1:0]};

  // R8
  rebar_mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SCHEME == int'(SZ_RESIZE) && is64) |-> (((bar_mask + 64'd1) & bar_mask) == 64'd0))
    else $error("resizable mask is not a contiguous run of low ones");

endmodule

// File: tb/test_bar_sizing_unit.sv
`timescale 1ns/1ps
module test_bar_sizing_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lcl_wr = 1'b0;
  logic [1:0]  lcl_addr = 2'd0;
  logic [31:0] lcl_wdata = '0;
  logic        shd_wr = 1'b0;
  logic [1:0]  shd_addr = 2'd0;
  logic [31:0] shd_wdata = '0;
  logic        hst_wr = 1'b0;
  logic        hst_hi = 1'b0;
  logic [31:0] hst_wdata = '0;

  logic [31:0] r_lrd, r_srd, r_hrd, p_lrd, p_srd, p_hrd, f_lrd, f_srd, f_hrd;
  logic        r_en, p_en, f_en;
  logic [63:0] r_base, r_mask, p_base, p_mask, f_base, f_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bar_sizing_unit #(.SCHEME(2)) i_bar_sizing_unit (
    .clk(clk), .rst_n(rst_n), .lcl_wr(lcl_wr), .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata),
    .lcl_rdata(r_lrd), .shd_wr(shd_wr), .shd_addr(shd_addr), .shd_wdata(shd_wdata),
    .shd_rdata(r_srd), .hst_wr(hst_wr), .hst_hi(hst_hi), .hst_wdata(hst_wdata),
    .hst_rdata(r_hrd), .bar_en(r_en), .bar_base(r_base), .bar_mask(r_mask));

  bar_sizing_unit #(.SCHEME(1)) i_prog (
    .clk(clk), .rst_n(rst_n), .lcl_wr(lcl_wr), .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata),
    .lcl_rdata(p_lrd), .shd_wr(shd_wr), .shd_addr(shd_addr), .shd_wdata(shd_wdata),
    .shd_rdata(p_srd), .hst_wr(hst_wr), .hst_hi(hst_hi), .hst_wdata(hst_wdata),
    .hst_rdata(p_hrd), .bar_en(p_en), .bar_base(p_base), .bar_mask(p_mask));

  bar_sizing_unit #(.SCHEME(0), .FIXED_MASK(64'h0000_0000_0000_FFFF)) i_fixed (
    .clk(clk), .rst_n(rst_n), .lcl_wr(lcl_wr), .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata),
    .lcl_rdata(f_lrd), .shd_wr(shd_wr), .shd_addr(shd_addr), .shd_wdata(shd_wdata),
    .shd_rdata(f_srd), .hst_wr(hst_wr), .hst_hi(hst_hi), .hst_wdata(hst_wdata),
    .hst_rdata(f_hrd), .bar_en(f_en), .bar_base(f_base), .bar_mask(f_mask));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic lcl_w(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); lcl_wr = 1'b1; lcl_addr = a; lcl_wdata = d;
    @(negedge clk); lcl_wr = 1'b0;
  endtask

  task automatic shd_w(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); shd_wr = 1'b1; shd_addr = a; shd_wdata = d;
    @(negedge clk); shd_wr = 1'b0;
  endtask

  task automatic hst_w(input logic hi, input logic [31:0] d);
    @(negedge clk); hst_wr = 1'b1; hst_hi = hi; hst_wdata = d;
    @(negedge clk); hst_wr = 1'b0;
  endtask

  task automatic hrd(input logic hi);
    hst_hi = hi; #1;
  endtask

  task automatic lrd(input logic [1:0] a);
    lcl_addr = a; #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [63:0] m;
    logic [31:0] ctrl_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    hrd(1'b0);
    chk("R1 host lo r", {32'd0, r_hrd}, 0);
    chk("R1 host lo p", {32'd0, p_hrd}, 0);
    chk("R1 bar_en", {61'd0, r_en, p_en, f_en}, 0);
    lrd(2'd2); chk("R1 cap", {32'd0, r_lrd}, 64'h10);
    lrd(2'd3); chk("R1 sel", {58'd0, r_lrd[13:8]}, 0);
    lrd(2'd0); chk("R1 flags", {60'd0, r_lrd[3:0]}, 0);
    shd_addr = 2'd2; #1; chk("R1 gate", {32'd0, r_srd}, 0);

    // R2: closed gate ignores local writes
    shd_w(2'd0, 32'h0000_0FFF);
    lcl_w(2'd0, 32'h0000_000C);
    lcl_w(2'd2, 32'h0000_0100);
    lcl_w(2'd3, 32'h0000_0000);
    chk("R2 enable r/p/f", {61'd0, r_en, p_en, f_en}, 0);
    lrd(2'd0); chk("R2 flags", {60'd0, r_lrd[3:0]}, 0);
    lrd(2'd2); chk("R2 cap", {32'd0, r_lrd}, 64'h10);
    lrd(2'd3); chk("R2 ext", {48'd0, r_lrd[31:16]}, 64'hFFFF);

    // open gate, 64-bit prefetchable memory flags
    shd_w(2'd2, 32'd1);
    lcl_w(2'd0, 32'h0000_000C);
    lrd(2'd0); chk("R11 flags set", {60'd0, p_lrd[3:0]}, 64'hC);
    lrd(2'd2); chk("R9 cap zero in prog", {32'd0, p_lrd}, 0);
    lrd(2'd3); chk("R9 ctrl zero in fixed", {32'd0, f_lrd}, 0);

    // R4 R5 R6 R8: programmable size sweep; fixed/resizable must ignore mask
    for (int k = 4; k <= 44; k++) begin
      m = (64'd1 << k) - 64'd1;
      shd_w(2'd0, m[31:0] | 32'd1);
      shd_w(2'd1, m[63:32]);
      hst_w(1'b0, 32'hFFFF_FFFF);
      hst_w(1'b1, 32'hFFFF_FFFF);
      hrd(1'b0);
      chk("R4 prog lo", {32'd0, p_hrd}, {32'd0, (~m[31:0] & 32'hFFFF_FFF0) | 32'hC});
      chk("R6 fixed lo", {32'd0, f_hrd}, 64'hFFFF_000C);
      chk("R8 rebar lo", {32'd0, r_hrd}, 64'hFFF0_000C);
      hrd(1'b1);
      chk("R5 prog hi", {32'd0, p_hrd}, {32'd0, ~m[63:32]});
      chk("R6 fixed hi", {32'd0, f_hrd}, 64'hFFFF_FFFF);
      chk("R5 prog mask out", p_mask, m | 64'hF);
    end

    // R7 R8: resizable capability sweep, extra high bit and low garbage
    for (int j = 0; j <= 27; j++) begin
      lcl_w(2'd2, (32'd1 << (j + 4)) | 32'h8000_000F);
      hst_w(1'b0, 32'hFFFF_FFFF);
      hst_w(1'b1, 32'hFFFF_FFFF);
      m = (64'd1 << (j + 20)) - 64'd1;
      lrd(2'd3); chk("R7 sel", {58'd0, r_lrd[13:8]}, 64'(j));
      hrd(1'b0); chk("R8 rebar lo", {32'd0, r_hrd}, {32'd0, (~m[31:0] & 32'hFFFF_FFF0) | 32'hC});
      hrd(1'b1); chk("R8 rebar hi", {32'd0, r_hrd}, {32'd0, ~m[63:32]});
    end

    // R7: no bit at or above 4 leaves size unchanged
    lcl_w(2'd2, 32'h0000_000F);
    lrd(2'd3); chk("R7 sel kept", {58'd0, r_lrd[13:8]}, 64'd27);
    lrd(2'd2); chk("R7 cap stored", {32'd0, r_lrd}, 64'hF);

    // R9: control layout and clearable extended sizes
    lrd(2'd3);
    ctrl_exp = {16'hFFFF, 2'b00, 6'd27, 3'd1, 2'b00, 3'd2};
    chk("R9 ctrl", {32'd0, r_lrd}, {32'd0, ctrl_exp});
    lcl_w(2'd3, 32'h0000_0000);
    lrd(2'd3);
    chk("R9 ctrl cleared", {32'd0, r_lrd}, {32'd0, 16'h0, ctrl_exp[15:0]});

    // R10: host base keeps only bits above the mask
    lcl_w(2'd2, 32'h0000_0010);
    hst_w(1'b0, 32'h1234_567F);
    hst_w(1'b1, 32'hDEAD_BEEF);
    hrd(1'b0); chk("R10 base lo", {32'd0, r_hrd}, 64'h1230_000C);
    hrd(1'b1); chk("R10 base hi", {32'd0, r_hrd}, 64'hDEAD_BEEF);
    chk("R10 base out", r_base, 64'hDEAD_BEEF_1230_0000);

    // R3: disabled BAR
    shd_w(2'd0, 32'd0);
    hrd(1'b0);
    chk("R3 bar_en", {63'd0, r_en}, 0);
    chk("R3 read zero", {32'd0, r_hrd}, 0);
    hst_w(1'b0, 32'h5555_5550);
    shd_w(2'd0, 32'd1);
    hrd(1'b0); chk("R3 write ignored", {32'd0, r_hrd}, 64'h1230_000C);

    // R2: closed gate keeps enable and flags
    shd_w(2'd2, 32'd0);
    shd_w(2'd0, 32'd0);
    lcl_w(2'd0, 32'h1230_0000);
    chk("R2 enable kept", {63'd0, r_en}, 1);
    lrd(2'd0); chk("R2 flags kept", {60'd0, r_lrd[3:0]}, 64'hC);

    // R11: 32-bit BAR
    shd_w(2'd2, 32'd1);
    lcl_w(2'd0, 32'h0000_0000);
    hst_w(1'b1, 32'hFFFF_FFFF);
    hst_w(1'b0, 32'hFFFF_FFFF);
    hrd(1'b1); chk("R11 hi zero", {32'd0, r_hrd}, 0);
    chk("R11 mask upper", {32'd0, r_mask[63:32]}, 0);
    hrd(1'b0); chk("R11 flags ro", {32'd0, r_hrd}, 64'hFFF0_0000);

    done = 1'b1;
    summary();
  end

endmodule